// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a serial stream of 8421 BCD digits into the matching Excess-3 stream, where each output digit is the input digit plus three. Bits arrive one per clock, least significant bit first, in groups of four. The first group starts on the first clock after reset is released. Consecutive digits follow each other with no idle cycle between them.

The converter is a Moore machine with eleven states. Each state records how many bits of the current digit have been seen, the output bit for that position, and the carry from adding three. The output therefore depends only on the present state. The output bit for an input bit appears in the clock after that input bit was sampled, which is one clock later than a Mealy formulation would give.

A parameter selects the reset state. The machine can reset into a dedicated start state, or into the equivalent end-of-digit state with output 0, which is the merged start. The output stream is the same in both cases.

Top module: `bcd_xs3_serial`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the machine returns to its start state and `z_o` is 0 after that edge. While reset is held, `x_i` has no effect on `z_o`.
- R2: For every digit value d from 0 to 9, sent as four bits least significant first, the four output bits form d+3, also least significant first. For example, 0 gives 0011 and 9 gives 1100.
- R3: `z_o` changes only after a rising clock edge. A change of `x_i` between edges leaves `z_o` unchanged until the next edge.
- R4: The output bit for the input bit sampled at edge k is present on `z_o` from edge k until edge k+1. The serial input 0,0,1,0,1,0,0,1 yields 1,1,1,0,0,0,1,1.
- R5: Digits may be sent back to back. The fifth bit after a digit start is bit 0 of the next digit, with no return through the start state.
- R6: For the out-of-range codes 13, 14 and 15, the fourth output bit is 1. The digit that follows is still aligned and converted correctly.
- R7: A reset in the middle of a digit discards the partial digit. The first bit after reset is released is bit 0 of a new digit.
- R8: With `MERGED_START` set to 1, the output stream is identical to that of the default build for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | 1 | Serial BCD input bit, LSB of each digit first |
| z_o | output | 1 | Registered serial Excess-3 output bit |

## Verification
The bench builds two copies side by side. One uses the default `MERGED_START` of 0, which resets into the dedicated start state. The other uses 1, which resets into the end-of-digit state. Every output bit of both copies is compared with the expected Excess-3 value, so any difference between the two reset variants shows up on the first digit after each reset. The first-digit-after-reset cases are the ones where the merged start could behave differently, together with the out-of-range path through the carry state at the third bit.

// File: rtl/bcd_xs3_pkg.sv
// Package: shared state type for the serial BCD to Excess-3 converter.
// State names encode digit position (P0..P3), the output bit (HI/LO) and
// whether a carry into the next position is pending (_C).
package bcd_xs3_pkg;

    localparam int DIGIT_BITS = 4;
    localparam int STATE_W    = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 4'd0,   // digit start, nothing seen
        ST_P0_HI   = 4'd1,   // bit0 out 1, no carry
        ST_P0_LO_C = 4'd2,   // bit0 out 0, carry
        ST_P1_HI   = 4'd3,   // bit1 out 1, no carry
        ST_P1_LO_C = 4'd4,   // bit1 out 0, carry
        ST_P1_HI_C = 4'd5,   // bit1 out 1, carry
        ST_P2_LO   = 4'd6,   // bit2 out 0, no carry
        ST_P2_HI   = 4'd7,   // bit2 out 1, no carry
        ST_P2_LO_C = 4'd8,   // bit2 out 0, carry
        ST_P3_LO   = 4'd9,   // bit3 out 0, digit done
        ST_P3_HI   = 4'd10   // bit3 out 1, digit done
    } xs3_state_t;

endpackage

// File: rtl/bcd_xs3_next.sv
// Module: next-state logic of the serial Excess-3 adder.
// Assumes the input bit belongs to the position implied by the present state.
// The carry state at the third position always moves to the high end state,
// so out-of-range codes never leave the defined states.
module bcd_xs3_next
    import bcd_xs3_pkg::*;
(
    input  xs3_state_t cur_i,
    input  logic       bit_i,
    output xs3_state_t nxt_o
);

    // Purpose: one transition per present state and input bit.
    always_comb begin
        unique case (cur_i)
            ST_IDLE:    nxt_o = bit_i ? ST_P0_LO_C : ST_P0_HI;
            ST_P0_HI:   nxt_o = bit_i ? ST_P1_LO_C : ST_P1_HI;
            ST_P0_LO_C: nxt_o = bit_i ? ST_P1_HI_C : ST_P1_LO_C;
            ST_P1_HI:   nxt_o = bit_i ? ST_P2_HI   : ST_P2_LO;
            ST_P1_LO_C,
            ST_P1_HI_C: nxt_o = bit_i ? ST_P2_LO_C : ST_P2_HI;
            ST_P2_LO,
            ST_P2_HI:   nxt_o = bit_i ? ST_P3_HI   : ST_P3_LO;
            ST_P2_LO_C: nxt_o = ST_P3_HI;
            ST_P3_LO,
            ST_P3_HI:   nxt_o = bit_i ? ST_P0_LO_C : ST_P0_HI;
            default:    nxt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bcd_xs3_out.sv
// Module: output decode of the Excess-3 machine.
// Assumes the output is a function of the state alone.
module bcd_xs3_out
    import bcd_xs3_pkg::*;
(
    input  xs3_state_t st_i,
    output logic       z_o
);

    // Purpose: map each state to the output bit it stands for.
    always_comb begin
        unique case (st_i)
            ST_P0_HI, ST_P1_HI, ST_P1_HI_C,
            ST_P2_HI, ST_P3_HI: z_o = 1'b1;
            default:            z_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcd_xs3_serial.sv
// Module: top of the serial BCD to Excess-3 converter.
// Holds the state register and a registered output bit. It assumes digit
// alignment begins on the first clock after reset is released.
// MERGED_START=1 resets into the equivalent end-of-digit state.
module bcd_xs3_serial
    import bcd_xs3_pkg::*;
#(
    parameter bit MERGED_START = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x_i,
    output logic z_o
);

    localparam xs3_state_t START_ST = MERGED_START ? ST_P3_LO : ST_IDLE;

    xs3_state_t state_q;
    xs3_state_t state_d;
    logic       z_d;

    bcd_xs3_next u_next (
        .cur_i (state_q),
        .bit_i (x_i),
        .nxt_o (state_d)
    );

    bcd_xs3_out u_out (
        .st_i (state_d),
        .z_o  (z_d)
    );

    // Purpose: advance the state and register the output bit of the new state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= START_ST;
            z_o     <= 1'b0;
        end else begin
            state_q <= state_d;
            z_o     <= z_d;
        end
    end

    // R1
    reset_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == START_ST) && !z_o);

    // R5
    digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P3_LO || state_q == ST_P3_HI)
        |=> (state_q == ST_P0_HI || state_q == ST_P0_LO_C));

    // R6
    overrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P2_LO_C) |=> (state_q == ST_P3_HI) && z_o);

    // R2
    lsb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P0_HI && $past(rst_n)) |-> !$past(x_i) && z_o);

endmodule

// File: tb/sim_bcd_xs3_serial.sv
// Bench: directed tasks, one per scenario, on two builds of the converter.
module sim_bcd_xs3_serial;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_i = 1'b0;
    logic z0, z1;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bcd_xs3_serial #(.MERGED_START(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .x_i(x_i), .z_o(z0));
    bcd_xs3_serial #(.MERGED_START(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .x_i(x_i), .z_o(z1));

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one bit at a falling edge, then check both builds one falling edge later.
    task automatic send_bit(input logic b, input logic exp, input string req);
        x_i = b;
        @(negedge clk);
        check(req, z0, exp);
        check({req, "/R8"}, z1, exp);
    endtask

    task automatic send_digit(input int d, input string req);
        logic [3:0] e;
        e = 4'(d + 3);
        for (int i = 0; i < 4; i++) send_bit(d[i], e[i], req);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            x_i = i[0];
            @(negedge clk);
            check("R1", z0, 1'b0);
            check("R1/R8", z1, 1'b0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(4);
    endtask

    // R2 R5: all ten digits back to back, twice with different order.
    task automatic t_all_digits();
        do_reset(1);
        for (int d = 0; d < 10; d++) send_digit(d, "R2");
        for (int d = 9; d >= 0; d--) send_digit(d, "R5");
    endtask

    // R4: the stream 0010_1001 gives 1110_0011.
    task automatic t_example();
        logic [7:0] xin  = 8'b0010_1001;
        logic [7:0] zexp = 8'b1110_0011;
        do_reset(1);
        for (int i = 7; i >= 0; i--) send_bit(xin[i], zexp[i], "R4");
    endtask

    // R3: toggling x_i mid-cycle leaves z_o unchanged until the edge.
    task automatic t_midcycle();
        logic held0, held1;
        do_reset(1);
        send_digit(2, "R3");
        held0 = z0;
        held1 = z1;
        x_i = 1'b1;
        #1;
        check("R3", z0, held0);
        check("R3/R8", z1, held1);
        send_bit(1'b0, 1'b1, "R3");   // digit 6: bit0 0 -> out 1
        send_bit(1'b1, 1'b0, "R3");
        send_bit(1'b1, 1'b0, "R3");
        send_bit(1'b0, 1'b1, "R3");
    endtask

    // R6: codes 13, 14, 15 end with output 1, next digit still aligned.
    task automatic t_overrange();
        logic [3:0] bad [3] = '{4'd13, 4'd14, 4'd15};
        do_reset(1);
        foreach (bad[k]) begin
            for (int i = 0; i < 3; i++) begin
                x_i = bad[k][i];
                @(negedge clk);
            end
            send_bit(bad[k][3], 1'b1, "R6");
            send_digit(5, "R6");
        end
    endtask

    // R7: reset in the middle of a digit restarts alignment.
    task automatic t_mid_reset();
        do_reset(1);
        send_digit(7, "R7");
        x_i = 1'b1;
        @(negedge clk);
        x_i = 1'b0;
        @(negedge clk);
        do_reset(1);
        send_digit(9, "R7");
        send_digit(0, "R7");
    endtask

    initial begin
        t_reset();
        t_all_digits();
        t_example();
        t_midcycle();
        t_overrange();
        t_mid_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule